// File: doc/BRIEF.md
# Programmable Ternary Unary Gate

This block applies one selectable single-input ternary function to a vector of trits, using the same function for every trit. A trit is carried on two binary wires. A 5-bit function code selects the function. The code is read as a signed value and then as a balanced-ternary number. Its three balanced digits give the function's outputs for the inputs +1, 0 and -1, with weights 9, 3 and 1. All 27 possible one-input ternary maps are therefore reachable, from constant -1 (code -13) to constant +1 (code +13).

The datapath is combinational. A parameter can add an output register that captures a new result only when `valid_in` is high. The block flags illegal trit encodings one trit at a time. It also flags codes that fall outside the 27 legal values. In either case it drives neutral zeros in place of the affected output.

Top module: `tern_unary_gate`

## Requirements
- R1: For a legal code v = 9·p + 3·z + n, with balanced digits p, z and n each in {-1, 0, +1}, an input trit +1 produces p, an input 0 produces z and an input -1 produces n.
- R2: Trits are encoded as 2'b00 = 0, 2'b01 = +1 and 2'b11 = -1, with trit i on bits [2i+1:2i]. No output trit ever carries 2'b10.
- R3: An input trit encoded 2'b10 drives its output trit to 2'b00 and sets bit i of `trit_err`. All other trits are computed normally.
- R4: `func_code` is 5-bit two's complement. The values +14, +15, -14, -15 and -16 set `code_err` and force every output trit to 0.
- R5: Each trit is mapped independently of its neighbours by the same function.
- R6: Code -8 (5'b11000) negates each trit. Code +8 (5'b01000) passes each trit through unchanged.
- R7: Code -6 (5'b11010) rotates each trit upward: -1 to 0, 0 to +1, +1 to -1. Code -2 (5'b11110) rotates each trit downward.
- R8: Code +12 gives +1 for inputs +1 and 0, and 0 for input -1. Code +10 is the absolute value. Code 0 outputs 0 for every input. Code +13 outputs all +1 and code -13 (5'b10011) outputs all -1.
- R9: Code +5 outputs +1 only for input +1, code -7 (5'b11001) only for input 0, and code -11 (5'b10101) only for input -1. In each case every other input gives -1.
- R10: With REG_OUT=1, the outputs take the result of the inputs present at a rising edge where `valid_in` is high, and hold otherwise; `valid_out` is `valid_in` delayed by one cycle. With REG_OUT=0, the outputs follow the inputs in the same cycle and `valid_out` equals `valid_in`.
- R11: While `rst_n` is low, the registered outputs, `trit_err`, `code_err` and `valid_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Input qualifier; enables capture into the output register |
| func_code | input | 5 | Signed function number, legal range -13..+13 |
| trits_in | input | 2*N_TRITS | Input trit vector |
| valid_out | output | 1 | Output qualifier |
| trits_out | output | 2*N_TRITS | Mapped trit vector |
| trit_err | output | N_TRITS | Per-trit illegal input encoding flag |
| code_err | output | 1 | Function code out of range |

## Verification
The assertions assume that `valid_in` stays low while reset is held. They also assume that `func_code` and `trits_in` are stable around each rising edge. They do not assume that either input is legal, so out-of-range codes and 2'b10 trits are part of the stimulus. The bench drives every input on the falling edge and keeps `valid_in` low during reset. It sweeps all 32 code values, including the five illegal ones, against vectors that mix legal and illegal trits.

// File: rtl/tern_pkg.sv
package tern_pkg;

   localparam int CODE_W    = 5;
   localparam int CODE_CNT  = 1 << CODE_W;
   localparam int CODE_LIM  = 13;

   typedef enum logic [1:0] {
      TRIT_ZERO = 2'b00,
      TRIT_POS  = 2'b01,
      TRIT_BAD  = 2'b10,
      TRIT_NEG  = 2'b11
   } trit_e;

   // outputs of one unary function, by input value
   typedef struct packed {
      trit_e on_pos;
      trit_e on_zero;
      trit_e on_neg;
   } tern_lut_t;

   localparam tern_lut_t LUT_NULL = '{TRIT_ZERO, TRIT_ZERO, TRIT_ZERO};

   typedef tern_lut_t [CODE_CNT-1:0] lut_tbl_t;

   // offset digit 0/1/2 -> trit -1/0/+1
   function automatic trit_e digit_to_trit(input logic [1:0] d);
      case (d)
         2'd0:    return TRIT_NEG;
         2'd1:    return TRIT_ZERO;
         default: return TRIT_POS;
      endcase
   endfunction

   function automatic logic code_in_range(input int v);
      return (v >= -CODE_LIM) && (v <= CODE_LIM);
   endfunction

   function automatic lut_tbl_t build_lut_tbl();
      lut_tbl_t tbl;
      for (int k = 0; k < CODE_CNT; k++) begin
         int v;
         int u;
         v = (k >= CODE_CNT/2) ? k - CODE_CNT : k;
         if (code_in_range(v)) begin
            u = v + CODE_LIM;
            tbl[k].on_pos  = digit_to_trit(2'(u / 9));
            tbl[k].on_zero = digit_to_trit(2'((u / 3) % 3));
            tbl[k].on_neg  = digit_to_trit(2'(u % 3));
         end else begin
            tbl[k] = LUT_NULL;
         end
      end
      return tbl;
   endfunction

   function automatic logic [CODE_CNT-1:0] build_ok_tbl();
      logic [CODE_CNT-1:0] ok;
      for (int k = 0; k < CODE_CNT; k++) begin
         ok[k] = code_in_range((k >= CODE_CNT/2) ? k - CODE_CNT : k);
      end
      return ok;
   endfunction

endpackage

// File: rtl/tern_code_lut.sv
module tern_code_lut
   import tern_pkg::*;
#(
   parameter bit DEC_TABLE = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   output tern_lut_t         lut,
   output logic              code_ok
);

   generate
      if (DEC_TABLE) begin : g_table
         localparam lut_tbl_t              LUT_TBL = build_lut_tbl();
         localparam logic [CODE_CNT-1:0]   OK_TBL  = build_ok_tbl();
         always_comb begin
            lut     = LUT_TBL[code];
            code_ok = OK_TBL[code];
         end
      end else begin : g_arith
         logic signed [CODE_W:0] code_sx;
         logic        [CODE_W:0] ofs;
         logic        [CODE_W:0] q_pos;
         logic        [CODE_W:0] q_zero;
         logic        [CODE_W:0] q_neg;
         always_comb begin
            code_sx = {code[CODE_W-1], code};
            code_ok = (code_sx >= -(CODE_W+1)'(CODE_LIM)) &&
                      (code_sx <=  (CODE_W+1)'(CODE_LIM));
            ofs     = code_sx + (CODE_W+1)'(CODE_LIM);
            q_pos   = ofs / (CODE_W+1)'(9);
            q_zero  = (ofs / (CODE_W+1)'(3)) % (CODE_W+1)'(3);
            q_neg   = ofs % (CODE_W+1)'(3);
            if (code_ok) begin
               lut.on_pos  = digit_to_trit(q_pos[1:0]);
               lut.on_zero = digit_to_trit(q_zero[1:0]);
               lut.on_neg  = digit_to_trit(q_neg[1:0]);
            end else begin
               lut = LUT_NULL;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tern_trit_map.sv
module tern_trit_map
   import tern_pkg::*;
(
   input  tern_lut_t   lut,
   input  logic [1:0]  t_in,
   output logic [1:0]  t_out,
   output logic        t_bad
);

   always_comb begin
      t_bad = 1'b0;
      case (t_in)
         TRIT_POS:  t_out = lut.on_pos;
         TRIT_ZERO: t_out = lut.on_zero;
         TRIT_NEG:  t_out = lut.on_neg;
         default: begin
            t_out = TRIT_ZERO;
            t_bad = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/tern_out_stage.sv
module tern_out_stage #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld_d,
   input  logic [W-1:0] d,
   output logic         vld_q,
   output logic [W-1:0] q
);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q     <= '0;
               vld_q <= 1'b0;
            end else begin
               if (vld_d) q <= d;
               vld_q <= vld_d;
            end
         end
      end else begin : g_wire
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign q     = d;
         assign vld_q = vld_d;
      end
   endgenerate

endmodule

// File: rtl/tern_unary_gate.sv
module tern_unary_gate
   import tern_pkg::*;
#(
   parameter int N_TRITS   = 8,
   parameter bit REG_OUT   = 1'b1,
   parameter bit DEC_TABLE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   valid_in,
   input  logic [CODE_W-1:0]      func_code,
   input  logic [2*N_TRITS-1:0]   trits_in,
   output logic                   valid_out,
   output logic [2*N_TRITS-1:0]   trits_out,
   output logic [N_TRITS-1:0]     trit_err,
   output logic                   code_err
);

   localparam int VEC_W = 2 * N_TRITS;
   localparam int PKT_W = VEC_W + N_TRITS + 1;

   generate
      if (N_TRITS < 1) begin : g_chk_n
         $error("tern_unary_gate: N_TRITS must be at least 1");
      end
   endgenerate

   tern_lut_t           lut;
   logic                code_ok;
   logic [VEC_W-1:0]    map_out;
   logic [N_TRITS-1:0]  map_bad;
   logic [PKT_W-1:0]    pkt_d;
   logic [PKT_W-1:0]    pkt_q;

   tern_code_lut #(
      .DEC_TABLE (DEC_TABLE)
   ) u_lut (
      .code    (func_code),
      .lut     (lut),
      .code_ok (code_ok)
   );

   generate
      for (genvar i = 0; i < N_TRITS; i++) begin : g_trit
         tern_trit_map u_map (
            .lut   (lut),
            .t_in  (trits_in[2*i +: 2]),
            .t_out (map_out[2*i +: 2]),
            .t_bad (map_bad[i])
         );
      end
   endgenerate

   assign pkt_d = {~code_ok, map_bad, map_out};

   tern_out_stage #(
      .W       (PKT_W),
      .REG_OUT (REG_OUT)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_d (valid_in),
      .d     (pkt_d),
      .vld_q (valid_out),
      .q     (pkt_q)
   );

   assign code_err  = pkt_q[PKT_W-1];
   assign trit_err  = pkt_q[VEC_W +: N_TRITS];
   assign trits_out = pkt_q[VEC_W-1:0];

endmodule

// File: rtl/tern_unary_gate_chk.sv
module tern_unary_gate_chk #(
   parameter int N_TRITS = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 valid_in,
   input logic [4:0]           func_code,
   input logic [2*N_TRITS-1:0] trits_in,
   input logic                 valid_out,
   input logic [2*N_TRITS-1:0] trits_out,
   input logic [N_TRITS-1:0]   trit_err,
   input logic                 code_err
);

   logic in_clean;
   always_comb begin
      in_clean = 1'b1;
      for (int i = 0; i < N_TRITS; i++)
         if (trits_in[2*i +: 2] == 2'b10) in_clean = 1'b0;
   end

   // R4: out-of-range code zeroes the vector
   a_r4_code_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      code_err |-> (trits_out == '0));

   generate
      for (genvar i = 0; i < N_TRITS; i++) begin : g_t
         // R2: no illegal encoding on the output
         a_r2_no_bad_out: assert property (@(posedge clk) disable iff (!rst_n)
            trits_out[2*i +: 2] != 2'b10);
         // R3: flagged trit is neutral
         a_r3_bad_trit_zero: assert property (@(posedge clk) disable iff (!rst_n)
            trit_err[i] |-> (trits_out[2*i +: 2] == 2'b00));
      end

      if (REG_OUT) begin : g_reg
         // R10: one-cycle qualifier delay
         a_r10_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (valid_out == $past(valid_in)));
         // R10: hold without valid
         a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(valid_in)) |->
               ($stable(trits_out) && $stable(trit_err) && $stable(code_err)));
         // R6: identity code passes trits one cycle later
         a_r6_identity: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && valid_in && in_clean && func_code == 5'd8) |->
               (trits_out == $past(trits_in)));
      end else begin : g_comb
         // R10: same-cycle qualifier
         a_r10_valid_pass: assert property (@(posedge clk) disable iff (!rst_n)
            valid_out == valid_in);
         // R6: identity code passes trits in the same cycle
         a_r6_identity: assert property (@(posedge clk) disable iff (!rst_n)
            (in_clean && func_code == 5'd8) |-> (trits_out == trits_in));
      end
   endgenerate

endmodule

bind tern_unary_gate tern_unary_gate_chk #(
   .N_TRITS (N_TRITS),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_in  (valid_in),
   .func_code (func_code),
   .trits_in  (trits_in),
   .valid_out (valid_out),
   .trits_out (trits_out),
   .trit_err  (trit_err),
   .code_err  (code_err)
);

// File: tb/tb_tern_unary_gate.sv
`timescale 1ns/1ps
module tb_tern_unary_gate;

   localparam int N  = 8;
   localparam int PW = 2*N + N + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            valid_in = 1'b0;
   logic [4:0]      func_code = '0;
   logic [2*N-1:0]  trits_in = '0;

   logic            r_vout, c_vout;
   logic [2*N-1:0]  r_tout, c_tout;
   logic [N-1:0]    r_terr, c_terr;
   logic            r_cerr, c_cerr;

   int n_cmp = 0;
   int n_bad = 0;
   string req = "R11";

   always #2 clk = ~clk;

   tern_unary_gate #(.N_TRITS(N), .REG_OUT(1'b1), .DEC_TABLE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .func_code(func_code),
      .trits_in(trits_in), .valid_out(r_vout), .trits_out(r_tout),
      .trit_err(r_terr), .code_err(r_cerr));

   tern_unary_gate #(.N_TRITS(N), .REG_OUT(1'b0), .DEC_TABLE(1'b0)) dut_comb (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .func_code(func_code),
      .trits_in(trits_in), .valid_out(c_vout), .trits_out(c_tout),
      .trit_err(c_terr), .code_err(c_cerr));

   // reference: search balanced digits, then map per trit
   function automatic logic [PW-1:0] ref_all(input logic [4:0] c, input logic [2*N-1:0] t);
      logic [PW-1:0] r;
      int v, p, z, m, y;
      bit found;
      r = '0; found = 0; p = 0; z = 0; m = 0;
      v = int'($signed(c));
      for (int i = -1; i <= 1; i++)
         for (int j = -1; j <= 1; j++)
            for (int k = -1; k <= 1; k++)
               if (9*i + 3*j + k == v) begin
                  p = i; z = j; m = k; found = 1;
               end
      r[PW-1] = !found;
      for (int n = 0; n < N; n++) begin
         case (t[2*n +: 2])
            2'b01: y = p;
            2'b00: y = z;
            2'b11: y = m;
            default: begin y = 0; r[2*N + n] = 1'b1; end
         endcase
         if (!found) y = 0;
         r[2*n +: 2] = (y == 1) ? 2'b01 : (y == -1) ? 2'b11 : 2'b00;
      end
      return r;
   endfunction

   logic [PW-1:0] exp_reg = '0;
   logic          exp_vld = 1'b0;
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_reg <= '0;
         exp_vld <= 1'b0;
      end else begin
         if (valid_in) exp_reg <= ref_all(func_code, trits_in);
         exp_vld <= valid_in;
      end
   end

   task automatic cmp(input string what, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_reg();
      cmp("reg data", {r_cerr, r_terr, r_tout}, exp_reg);
      cmp("reg valid", PW'(r_vout), PW'(exp_vld));
   endtask

   task automatic chk_comb();
      cmp("comb data", {c_cerr, c_terr, c_tout}, ref_all(func_code, trits_in));
      cmp("comb valid", PW'(c_vout), PW'(valid_in));
   endtask

   task automatic apply(input logic v, input logic [4:0] c, input logic [2*N-1:0] t);
      @(negedge clk);
      chk_reg();
      valid_in = v; func_code = c; trits_in = t;
      #1;
      chk_comb();
   endtask

   logic [31:0] lfsr = 32'h1ACE_5EED;
   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x;
      x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      return x;
   endfunction

   // every trit legal: map illegal pairs 10 -> 11
   function automatic logic [2*N-1:0] legalize(input logic [2*N-1:0] t);
      logic [2*N-1:0] r;
      r = t;
      for (int n = 0; n < N; n++) if (r[2*n +: 2] == 2'b10) r[2*n +: 2] = 2'b11;
      return r;
   endfunction

   // mix of all three values: +1,0,-1,+1,-1,0,0,+1
   localparam logic [2*N-1:0] MIX = 16'b01_00_00_11_01_11_00_01;

   bit done = 0;
   initial begin
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R11: reset state
      req = "R11";
      func_code = 5'd13; trits_in = MIX;
      repeat (3) begin
         @(negedge clk);
         chk_reg();
      end
      @(negedge clk);
      rst_n = 1'b1;

      req = "R2";
      apply(1, 5'd8, MIX);
      apply(1, 5'd8, 16'h5555);
      req = "R6";
      apply(1, 5'b11000, MIX);
      apply(1, 5'b11000, 16'hFFFF);
      apply(1, 5'd8, 16'h0000);
      req = "R7";
      apply(1, 5'b11010, MIX);
      apply(1, 5'b11110, MIX);
      req = "R8";
      apply(1, 5'd12, MIX);
      apply(1, 5'd10, MIX);
      apply(1, 5'd0, MIX);
      apply(1, 5'd13, MIX);
      apply(1, 5'b10011, MIX);
      req = "R9";
      apply(1, 5'd5, MIX);
      apply(1, 5'b11001, MIX);
      apply(1, 5'b10101, MIX);
      req = "R4";
      apply(1, 5'd14, MIX);
      apply(1, 5'd15, 16'hFFFF);
      apply(1, 5'b10010, MIX);
      apply(1, 5'b10001, 16'h5555);
      apply(1, 5'b10000, MIX);
      req = "R3";
      apply(1, 5'b11000, 16'b10_01_00_11_10_10_01_00);
      apply(1, 5'd14, 16'b01_10_11_00_00_00_00_10);
      apply(1, 5'd13, 16'hAAAA);
      req = "R10";
      apply(1, 5'd5, MIX);
      apply(0, 5'b11000, 16'hFFFF);
      apply(0, 5'd14, 16'hAAAA);
      apply(0, 5'd0, 16'h5555);
      apply(1, 5'd12, 16'h0000);
      apply(0, 5'd10, MIX);
      req = "R5";
      for (int k = 0; k < 40; k++) begin
         lfsr = nxt(lfsr);
         apply(1, 5'(k % 27 - 13), legalize(lfsr[2*N-1:0]));
      end
      req = "R1";
      for (int c = -16; c < 16; c++) begin
         for (int k = 0; k < 4; k++) begin
            lfsr = nxt(lfsr);
            apply(lfsr[20] | (k != 3), 5'(c), lfsr[2*N-1:0]);
         end
      end
      @(negedge clk);
      chk_reg();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule